// File: doc/BRIEF.md
# Set-Dueling Policy Selector

This block picks which of two cache replacement policies the bulk of a cache should use. A fixed group of sampled sets is watched. For each sampled set the block keeps two small shadow directories, one per candidate policy, holding shortened tags. Every access to a sampled set is looked up in both shadow directories. Each directory is then updated under its own policy, so the two directories model what each policy would have kept in that set.

A shared saturating score counter records which policy is ahead. It moves only when the two shadows disagree on hit versus miss. Its most significant bit is the policy choice handed to all non-sampled sets. The real data array and the real tag array of the cache are outside this block.

The two candidates share their victim choice: the lowest-numbered invalid way, and otherwise the least recently used way. They differ only in where a newly filled line enters the recency stack. Policy 0 places it at most-recent. Policy 1 places it at least-recent, which resists thrashing. The score logic classifies each sampled access with a three-valued verdict: `VERDICT_TIE`, `VERDICT_FAVOR0` or `VERDICT_FAVOR1`. The counter steps on that verdict.

Top module: `dsel_top`

## Requirements
- R1: After reset every shadow entry is invalid. The score counter holds 2^(CNT_W-1), so `policy_sel` is 1 and `res_valid` is 0.
- R2: An access is sampled only when `acc_set[SET_W-1:SLOT_W]` equals `SAMPLE_PAT`, and `acc_set[SLOT_W-1:0]` then names the sampled slot. Any other access leaves `res_valid` at 0 on the next cycle and changes neither shadow directory nor the counter.
- R3: One clock after a sampled access, `res_valid` is 1 and `res_hit0` / `res_hit1` report whether shadow 0 / shadow 1 held the tag.
- R4: Only the low PT_W bits of `acc_tag` are stored and compared. Tags that differ only above bit PT_W-1 hit the same entry.
- R5: Shadow 0 on a miss fills the lowest invalid way, or else the least recently used way, and makes the filled way most recent. A hit makes the way most recent.
- R6: Shadow 1 picks its victim as in R5 but leaves the filled way least recent. A hit makes the way most recent.
- R7: When shadow 0 hits and shadow 1 misses, the counter decrements by one. When shadow 1 hits and shadow 0 misses, it increments by one. In every other case it holds.
- R8: The counter saturates at 0 and at 2^CNT_W-1 and never wraps.
- R9: `policy_sel` is the counter's most significant bit: 0 selects policy 0 and 1 selects policy 1.
- R10: An access in the cycle directly after another sampled access to the same slot sees the shadow state that the earlier access left.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Access strobe |
| acc_set | input | SET_W | Set index of the access |
| acc_tag | input | TAG_W | Full tag of the access |
| policy_sel | output | 1 | Policy for non-sampled sets |
| res_valid | output | 1 | Hit flags below are valid (sampled access one cycle earlier) |
| res_hit0 | output | 1 | Shadow directory of policy 0 hit |
| res_hit1 | output | 1 | Shadow directory of policy 1 hit |

## Verification
The bench builds the block with 4 ways, a 4-bit counter, 8-bit set index, 20-bit tag and 3-bit sample pattern, keeping 32 slots and 16-bit partial tags. Four ways let a five-tag sequence force a miss in one shadow and a hit in the other, so each counter step can be provoked on purpose. A 4-bit counter lets both saturation limits and the midpoint crossing of `policy_sel` be reached in a few dozen accesses. The 20-bit tag leaves upper bits that can differ while the partial tag stays equal, which is how aliasing is exercised.

// File: rtl/dsel_pkg.sv
package dsel_pkg;
    // Outcome of one sampled access as seen by the score counter
    typedef enum logic [1:0] {
        VERDICT_TIE    = 2'd0,
        VERDICT_FAVOR0 = 2'd1,
        VERDICT_FAVOR1 = 2'd2
    } verdict_e;
endpackage

// File: rtl/dsel_shadow_dir.sv
module dsel_shadow_dir #(
    parameter int SLOTS       = 32,
    parameter int WAYS        = 16,
    parameter int PT_W        = 16,
    parameter bit FILL_AT_LRU = 1'b0,
    localparam int SLOT_W = $clog2(SLOTS),
    localparam int WAY_W  = $clog2(WAYS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              upd_en,
    input  logic [SLOT_W-1:0] slot,
    input  logic [PT_W-1:0]   ptag,
    output logic              hit
);
    localparam logic [WAY_W-1:0] OLDEST = WAY_W'(WAYS - 1);

    logic [WAYS-1:0]  vld_q [SLOTS];
    logic [PT_W-1:0]  tag_q [SLOTS][WAYS];
    logic [WAY_W-1:0] age_q [SLOTS][WAYS];

    logic [WAYS-1:0]  hit_vec;
    logic [WAY_W-1:0] hit_idx, inv_idx, lru_idx, touch, old_age;
    logic             any_inv, to_oldest;
    logic [WAY_W-1:0] new_age [WAYS];

    always_comb begin
        hit_idx = '0;
        inv_idx = '0;
        lru_idx = '0;
        any_inv = 1'b0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            hit_vec[w] = vld_q[slot][w] && (tag_q[slot][w] == ptag);
            if (hit_vec[w]) hit_idx = WAY_W'(w);
            if (!vld_q[slot][w]) begin
                inv_idx = WAY_W'(w);
                any_inv = 1'b1;
            end
            if (age_q[slot][w] == OLDEST) lru_idx = WAY_W'(w);
        end
        hit       = |hit_vec;
        touch     = hit ? hit_idx : (any_inv ? inv_idx : lru_idx);
        old_age   = age_q[slot][touch];
        to_oldest = FILL_AT_LRU && !hit;
        for (int w = 0; w < WAYS; w++) begin
            new_age[w] = age_q[slot][w];
            if (WAY_W'(w) == touch)
                new_age[w] = to_oldest ? OLDEST : '0;
            else if (!to_oldest && age_q[slot][w] < old_age)
                new_age[w] = age_q[slot][w] + 1'b1;
            else if (to_oldest && age_q[slot][w] > old_age)
                new_age[w] = age_q[slot][w] - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SLOTS; s++) begin
                vld_q[s] <= '0;
                for (int w = 0; w < WAYS; w++) age_q[s][w] <= WAY_W'(w);
            end
        end else if (upd_en) begin
            vld_q[slot][touch] <= 1'b1;
            for (int w = 0; w < WAYS; w++) age_q[slot][w] <= new_age[w];
        end
    end

    always_ff @(posedge clk) begin
        if (upd_en) tag_q[slot][touch] <= ptag;
    end

    // Recency positions within the addressed slot must stay a permutation
    logic [WAYS-1:0] age_seen;
    always_comb begin
        age_seen = '0;
        for (int w = 0; w < WAYS; w++) age_seen[age_q[slot][w]] = 1'b1;
    end

    assert_ages_distinct_R5: assert property (@(posedge clk) disable iff (!rst_n)
        &age_seen);
    assert_single_match_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit_vec));
endmodule

// File: rtl/dsel_sat_ctr.sv
module dsel_sat_ctr
    import dsel_pkg::*;
#(
    parameter int CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  verdict_e         verdict,
    output logic [CNT_W-1:0] cnt
);
    localparam logic [CNT_W-1:0] MID = CNT_W'(1) << (CNT_W - 1);
    localparam logic [CNT_W-1:0] TOP = '1;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= MID;
        end else begin
            unique case (verdict)
                VERDICT_FAVOR0: if (cnt != '0) cnt <= cnt - 1'b1;
                VERDICT_FAVOR1: if (cnt != TOP) cnt <= cnt + 1'b1;
                default:        cnt <= cnt;
            endcase
        end
    end

    assert_hold_on_tie_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (verdict == VERDICT_TIE) |=> $stable(cnt));
    assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == TOP && verdict == VERDICT_FAVOR1) |=> (cnt == TOP));
    assert_no_underflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == '0 && verdict == VERDICT_FAVOR0) |=> (cnt == '0));
endmodule

// File: rtl/dsel_top.sv
module dsel_top
    import dsel_pkg::*;
#(
    parameter int          SET_W      = 10,
    parameter int          SLOTS      = 32,
    parameter int          TAG_W      = 32,
    parameter int          PT_W       = 16,
    parameter int          WAYS       = 16,
    parameter int          CNT_W      = 10,
    parameter logic [31:0] SAMPLE_PAT = 32'h15
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             acc_valid,
    input  logic [SET_W-1:0] acc_set,
    input  logic [TAG_W-1:0] acc_tag,
    output logic             policy_sel,
    output logic             res_valid,
    output logic             res_hit0,
    output logic             res_hit1
);
    localparam int SLOT_W = $clog2(SLOTS);
    localparam int UP_W   = SET_W - SLOT_W;

    logic             sampled;
    logic [PT_W-1:0]  ptag;
    logic [1:0]       pol_hit;
    verdict_e         verdict;
    logic [CNT_W-1:0] score;
    logic             unused_tag_hi;

    assign sampled       = acc_valid && (acc_set[SET_W-1:SLOT_W] == SAMPLE_PAT[UP_W-1:0]);
    assign ptag          = acc_tag[PT_W-1:0];
    assign unused_tag_hi = ^acc_tag[TAG_W-1:PT_W];

    for (genvar g = 0; g < 2; g++) begin : g_shadow
        dsel_shadow_dir #(
            .SLOTS      (SLOTS),
            .WAYS       (WAYS),
            .PT_W       (PT_W),
            .FILL_AT_LRU(g == 1)
        ) u_dir (
            .clk   (clk),
            .rst_n (rst_n),
            .upd_en(sampled),
            .slot  (acc_set[SLOT_W-1:0]),
            .ptag  (ptag),
            .hit   (pol_hit[g])
        );
    end

    always_comb begin
        verdict = VERDICT_TIE;
        if (sampled && pol_hit[0] && !pol_hit[1]) verdict = VERDICT_FAVOR0;
        if (sampled && pol_hit[1] && !pol_hit[0]) verdict = VERDICT_FAVOR1;
    end

    dsel_sat_ctr #(.CNT_W(CNT_W)) u_score (
        .clk    (clk),
        .rst_n  (rst_n),
        .verdict(verdict),
        .cnt    (score)
    );

    assign policy_sel = score[CNT_W-1];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid <= 1'b0;
            res_hit0  <= 1'b0;
            res_hit1  <= 1'b0;
        end else begin
            res_valid <= sampled;
            res_hit0  <= sampled && pol_hit[0];
            res_hit1  <= sampled && pol_hit[1];
        end
    end

    assert_quiet_unsampled_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !sampled |=> !res_valid);
    assert_report_sampled_R3: assert property (@(posedge clk) disable iff (!rst_n)
        sampled |=> res_valid);
    assert_sel_stable_on_tie_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !sampled |=> $stable(policy_sel));
endmodule

// File: tb/dsel_top_tb.sv
module dsel_top_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_valid = 1'b0;
    logic [7:0]  acc_set = '0;
    logic [19:0] acc_tag = '0;
    logic        policy_sel, res_valid, res_hit0, res_hit1;
    int          checks = 0;
    int          failures = 0;

    always #4 clk = ~clk;

    dsel_top #(
        .SET_W(8), .SLOTS(32), .TAG_W(20), .PT_W(16),
        .WAYS(4), .CNT_W(4), .SAMPLE_PAT(32'h5)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_set(acc_set),
        .acc_tag(acc_tag), .policy_sel(policy_sel), .res_valid(res_valid),
        .res_hit0(res_hit0), .res_hit1(res_hit1)
    );

    function automatic logic [7:0] sset(input int slot);
        return {3'b101, 5'(slot)};
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic do_reset;
        @(negedge clk);
        rst_n = 1'b0;
        acc_valid = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic acc(input logic [7:0] s, input logic [19:0] t);
        @(negedge clk);
        acc_valid = 1'b1;
        acc_set = s;
        acc_tag = t;
        @(negedge clk);
        acc_valid = 1'b0;
    endtask

    task automatic expect_res(input string req, input bit v, input bit h0, input bit h1);
        chk(res_valid == v, req, "res_valid", res_valid, v);
        chk(res_hit0 == h0, req, "res_hit0", res_hit0, h0);
        chk(res_hit1 == h1, req, "res_hit1", res_hit1, h1);
    endtask

    // Five tags into a 4-way slot then revisit the first: shadow 1 alone hits
    task automatic seq_up(input int slot, input logic [19:0] base, input bit exp_sel);
        for (int i = 0; i < 5; i++) acc(sset(slot), base + 20'(i));
        acc(sset(slot), base);
        expect_res("R6", 1'b1, 1'b0, 1'b1);
        chk(policy_sel == exp_sel, "R8", "policy_sel after step up", policy_sel, exp_sel);
    endtask

    // Five tags then revisit the fourth: shadow 0 alone hits
    task automatic seq_down(input int slot, input logic [19:0] base, input bit exp_sel);
        for (int i = 0; i < 5; i++) acc(sset(slot), base + 20'(i));
        acc(sset(slot), base + 20'd3);
        expect_res("R5", 1'b1, 1'b1, 1'b0);
        chk(policy_sel == exp_sel, "R8", "policy_sel after step down", policy_sel, exp_sel);
    endtask

    task automatic t_reset;
        do_reset();
        @(negedge clk);
        chk(res_valid == 1'b0, "R1", "res_valid after reset", res_valid, 0);
        chk(policy_sel == 1'b1, "R1", "policy_sel at midpoint", policy_sel, 1);
    endtask

    task automatic t_basic;
        do_reset();
        for (int i = 0; i < 4; i++) begin
            acc(sset(0), 20'h00A00 + 20'(i));
            expect_res("R3", 1'b1, 1'b0, 1'b0);
        end
        acc(sset(0), 20'h00A04);
        expect_res("R3", 1'b1, 1'b0, 1'b0);
        acc(sset(0), 20'h00A00);
        expect_res("R6", 1'b1, 1'b0, 1'b1);
        chk(policy_sel == 1'b1, "R7", "sel after +1 (9)", policy_sel, 1);
        acc(sset(0), 20'h00A03);
        expect_res("R5", 1'b1, 1'b1, 1'b0);
        chk(policy_sel == 1'b1, "R7", "sel after -1 (8)", policy_sel, 1);
        seq_down(1, 20'h00B00, 1'b0);
        chk(policy_sel == 1'b0, "R9", "sel drops below midpoint", policy_sel, 0);
        seq_up(2, 20'h00C00, 1'b1);
        chk(policy_sel == 1'b1, "R9", "sel back at midpoint", policy_sel, 1);
    endtask

    task automatic t_unsampled;
        do_reset();
        for (int i = 0; i < 4; i++) acc(sset(3), 20'h00D00 + 20'(i));
        acc({3'b001, 5'd3}, 20'h00D04);
        expect_res("R2", 1'b0, 1'b0, 1'b0);
        acc(sset(3), 20'h00D00);
        expect_res("R2", 1'b1, 1'b1, 1'b1);
        chk(policy_sel == 1'b1, "R2", "sel unchanged", policy_sel, 1);
    endtask

    task automatic t_alias;
        do_reset();
        acc(sset(4), 20'h12345);
        expect_res("R4", 1'b1, 1'b0, 1'b0);
        acc(sset(4), 20'h52345);
        expect_res("R4", 1'b1, 1'b1, 1'b1);
        acc(sset(4), 20'h52346);
        expect_res("R4", 1'b1, 1'b0, 1'b0);
        // Back-to-back pair to one slot
        @(negedge clk);
        acc_valid = 1'b1;
        acc_set = sset(5);
        acc_tag = 20'h0E000;
        @(negedge clk);
        expect_res("R10", 1'b1, 1'b0, 1'b0);
        @(negedge clk);
        acc_valid = 1'b0;
        expect_res("R10", 1'b1, 1'b1, 1'b1);
    endtask

    task automatic t_sat_high;
        do_reset();
        for (int k = 0; k < 10; k++) seq_up(k, 20'h01000 + 20'(k * 16), 1'b1);
        for (int k = 10; k < 17; k++) seq_down(k, 20'h01000 + 20'(k * 16), 1'b1);
        seq_down(17, 20'h01200, 1'b0);
    endtask

    task automatic t_sat_low;
        do_reset();
        for (int k = 0; k < 11; k++) seq_down(k, 20'h02000 + 20'(k * 16), 1'b0);
        for (int k = 11; k < 18; k++) seq_up(k, 20'h02000 + 20'(k * 16), 1'b0);
        seq_up(18, 20'h02200, 1'b1);
    endtask

    initial begin
        t_reset();
        t_basic();
        t_unsampled();
        t_alias();
        t_sat_high();
        t_sat_low();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule